// File: doc/BRIEF.md
# Byte-Lane Predicate Mask Generator

This combinational block computes which byte lanes of a 128-bit vector result may be written. Its output is a 16-bit enable mask, one bit per byte lane, where 1 means the lane is written. Operations on wider elements read a subset of the bits. Byte operations use every bit. Halfword operations use the even bits. Word operations use bits 0, 4, 8 and 12.

Three restrictions are applied in turn to an all-enabled starting point, and the results are combined by AND:

- **Stored predicate.** The predicate is stored as sixteen lane bits together with two 4-bit block-enable codes. When a block code is zero, the half of the vector it governs is fully enabled, whatever its lane bits say.
- **Loop tail.** On the final pass of a counted loop, lanes above the remaining element count are cut off.
- **Resumed instruction.** When an instruction resumes after an interruption, the beats it already completed are suppressed. Each beat covers four lanes.

A beat-state value that has no defined meaning is reported on a separate error output.

Top module: `lane_mask_gen`

## Requirements
- R1: With both block codes zero, a size code of 4 or more and a beat state of 0x00, `laneMask` is 16'hFFFF and `beatIllegal` is 0.
- R2: When `blockMaskLo` is zero, lanes 7:0 of the stored-predicate stage are forced to 1, whatever `predBits[7:0]` holds.
- R3: When `blockMaskHi` is zero, lanes 15:8 of the stored-predicate stage are forced to 1. A half whose block code is nonzero follows `predBits` bit for bit.
- R4: The loop-tail stage is active when `sizeCode` < 4 and `loopCount` <= (16 >> `sizeCode`). When it is active, only the low (`loopCount` << `sizeCode`) lanes survive, and a count of 0 clears every lane.
- R5: A `sizeCode` of 4 to 7, or a `loopCount` above the threshold in R4, leaves the mask untouched by the tail stage. This holds even for very large counts.
- R6: The beat stage acts only when `beatState[3:0]` is 0, and it takes its code from `beatState[7:4]`. A nonzero low nibble disables the stage and holds `beatIllegal` low.
- R7: Beat code 1 (first beat done) clears lanes 3:0. Beat code 2 (two beats done) clears lanes 7:0. Beat code 0 clears nothing.
- R8: Beat code 3 (three beats done) and beat code 4 (three beats done plus the first beat of the next instruction) both clear lanes 11:0.
- R9: Beat codes 5 to 15, when the low nibble is 0, raise `beatIllegal`, and the beat stage then clears no lane.
- R10: The three stages combine by AND. No lane is ever enabled that the stored-predicate stage disables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| predBits | input | 16 | Stored per-lane predicate bits |
| blockMaskLo | input | 4 | Block-enable code for lanes 7:0; zero means the half is unpredicated |
| blockMaskHi | input | 4 | Block-enable code for lanes 15:8; zero means the half is unpredicated |
| sizeCode | input | 3 | Tail element-size code: log2 of the element bytes, with 4 or more meaning no tail |
| loopCount | input | 32 | Remaining element count of the loop |
| beatState | input | 8 | Condition/beat-state byte; the high nibble is the beat code when the low nibble is 0 |
| laneMask | output | 16 | Per-byte-lane write enable |
| beatIllegal | output | 1 | Beat code 5 to 15 seen while the beat stage is active |

## Verification
The bench builds the block at its default 32-bit counter and 3-bit size code. This makes every size code reachable, including the disabled codes 5 to 7, as well as counts far above any tail threshold. A sweep covers all sixteen beat codes, with the low nibble both zero and nonzero. It crosses them with counts 0 to 17, every size code, and each forcing state of the two block codes, and compares the result lane by lane against a model written independently in the bench. This sweep includes the exact-threshold counts where the tail keeps all 16 lanes.

// File: rtl/lane_mask_pkg.sv
package lane_mask_pkg;
  localparam int unsigned LANES      = 16;
  localparam int unsigned LOG2_LANES = $clog2(LANES);
  localparam int unsigned HALF_LANES = LANES / 2;
  localparam int unsigned BEATS      = 4;
  localparam int unsigned BEAT_LANES = LANES / BEATS;
  localparam int unsigned BLK_W      = 4;
  localparam int unsigned LEN_W      = LOG2_LANES + 1;
  localparam int unsigned SKIP_W     = $clog2(BEATS);

  typedef enum logic [3:0] {
    BEAT_NONE       = 4'd0,
    BEAT_ONE        = 4'd1,
    BEAT_TWO        = 4'd2,
    BEAT_THREE      = 4'd3,
    BEAT_THREE_NEXT = 4'd4
  } beatCode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic              tailEn;
    logic [LEN_W-1:0]  tailLen;
    logic [SKIP_W-1:0] skipBeats;
    logic              illegal;
  } maskCtrl_t;
endpackage

// File: rtl/lane_mask_ctrl.sv
module lane_mask_ctrl
  import lane_mask_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned SIZE_W = 3
) (
  input  logic [SIZE_W-1:0] sizeCode,
  input  logic [CNT_W-1:0]  loopCount,
  input  logic [7:0]        beatState,
  output maskCtrl_t         ctrl
);
  logic [CNT_W-1:0] tailThresh;

  always_comb begin
    ctrl       = '0;
    tailThresh = CNT_W'(LANES) >> sizeCode;
    // Tail stage: the final pass keeps count*esize lanes.
    if ((sizeCode < SIZE_W'(LOG2_LANES)) && (loopCount <= tailThresh)) begin
      ctrl.tailEn  = 1'b1;
      ctrl.tailLen = loopCount[LEN_W-1:0] << sizeCode;
    end
    // Beat stage: suppress beats already completed.
    if (beatState[3:0] == 4'd0) begin
      case (beatCode_e'(beatState[7:4]))
        BEAT_NONE:                   ctrl.skipBeats = SKIP_W'(0);
        BEAT_ONE:                    ctrl.skipBeats = SKIP_W'(1);
        BEAT_TWO:                    ctrl.skipBeats = SKIP_W'(2);
        BEAT_THREE, BEAT_THREE_NEXT: ctrl.skipBeats = SKIP_W'(3);
        default:                     ctrl.illegal   = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/lane_mask_dp.sv
module lane_mask_dp
  import lane_mask_pkg::*;
(
  input  logic [LANES-1:0] predBits,
  input  logic [BLK_W-1:0] blockMaskLo,
  input  logic [BLK_W-1:0] blockMaskHi,
  input  maskCtrl_t        ctrl,
  output logic [LANES-1:0] laneMask
);
  logic loFree, hiFree;
  assign loFree = (blockMaskLo == '0);
  assign hiFree = (blockMaskHi == '0);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic blockOn, tailKeep, beatKeep;
    if (i < HALF_LANES) begin : g_lo
      assign blockOn = predBits[i] | loFree;
    end else begin : g_hi
      assign blockOn = predBits[i] | hiFree;
    end
    assign tailKeep = !ctrl.tailEn || (LEN_W'(i) < ctrl.tailLen);
    assign beatKeep = (SKIP_W'(i / BEAT_LANES) >= ctrl.skipBeats);
    assign laneMask[i] = blockOn & tailKeep & beatKeep;
  end
endmodule

// File: rtl/lane_mask_gen.sv
module lane_mask_gen
  import lane_mask_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned SIZE_W = 3
) (
  input  logic [15:0]       predBits,
  input  logic [3:0]        blockMaskLo,
  input  logic [3:0]        blockMaskHi,
  input  logic [SIZE_W-1:0] sizeCode,
  input  logic [CNT_W-1:0]  loopCount,
  input  logic [7:0]        beatState,
  output logic [15:0]       laneMask,
  output logic              beatIllegal
);
  maskCtrl_t ctrl;

  lane_mask_ctrl #(.CNT_W(CNT_W), .SIZE_W(SIZE_W)) u_ctrl (
    .sizeCode (sizeCode),
    .loopCount(loopCount),
    .beatState(beatState),
    .ctrl     (ctrl)
  );

  lane_mask_dp u_dp (
    .predBits   (predBits),
    .blockMaskLo(blockMaskLo),
    .blockMaskHi(blockMaskHi),
    .ctrl       (ctrl),
    .laneMask   (laneMask)
  );

  assign beatIllegal = ctrl.illegal;
endmodule

// File: rtl/lane_mask_gen_chk.sv
module lane_mask_gen_chk #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned SIZE_W = 3
) (
  input logic [15:0]       predBits,
  input logic [3:0]        blockMaskLo,
  input logic [3:0]        blockMaskHi,
  input logic [SIZE_W-1:0] sizeCode,
  input logic [CNT_W-1:0]  loopCount,
  input logic [7:0]        beatState,
  input logic [15:0]       laneMask,
  input logic              beatIllegal
);
  logic [15:0] allowed;
  assign allowed = predBits | {{8{blockMaskHi == 4'd0}}, {8{blockMaskLo == 4'd0}}};

  always_comb begin
    if (blockMaskLo == 4'd0 && sizeCode >= SIZE_W'(4) && beatState == 8'h00)
      assert_lo_forced_R2: assert (laneMask[7:0] == 8'hFF) else $error("lo half not forced");
    if (blockMaskHi == 4'd0 && sizeCode >= SIZE_W'(4) && beatState == 8'h00)
      assert_hi_forced_R3: assert (laneMask[15:8] == 8'hFF) else $error("hi half not forced");
    if (sizeCode < SIZE_W'(4) && loopCount == '0)
      assert_zero_count_R4: assert (laneMask == 16'h0000) else $error("zero count kept lanes");
    if (beatState == 8'h10)
      assert_first_beat_R7: assert (laneMask[3:0] == 4'h0) else $error("beat 0 lanes kept");
    if (beatState[3:0] == 4'd0 && (beatState[7:4] == 4'd3 || beatState[7:4] == 4'd4))
      assert_three_beats_R8: assert (laneMask[11:0] == 12'h000) else $error("beats 0-2 kept");
    assert_illegal_R9: assert (beatIllegal == (beatState[3:0] == 4'd0 && beatState[7:4] > 4'd4))
      else $error("illegal flag mismatch");
    assert_within_pred_R10: assert ((laneMask & ~allowed) == 16'h0000) else $error("lane beyond predicate");
  end
endmodule

bind lane_mask_gen lane_mask_gen_chk #(.CNT_W(CNT_W), .SIZE_W(SIZE_W)) chk (.*);

// File: tb/tb_lane_mask_gen.sv
module tb_lane_mask_gen;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] predBits;
  logic [3:0]  blockMaskLo, blockMaskHi;
  logic [2:0]  sizeCode;
  logic [31:0] loopCount;
  logic [7:0]  beatState;
  logic [15:0] laneMask;
  logic        beatIllegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  lane_mask_gen dut (.*);

  typedef struct packed {
    logic [15:0] pred; logic [3:0] lo; logic [3:0] hi; logic [2:0] size;
    logic [31:0] cnt; logic [7:0] beat; logic [15:0] expMask; logic expErr;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 4'h0, 4'h0, 3'd4, 32'd0,  8'h00, 16'hFFFF, 1'b0}, // R1
    '{16'h1234, 4'h0, 4'h8, 3'd4, 32'd0,  8'h00, 16'h12FF, 1'b0}, // R2
    '{16'h1234, 4'h8, 4'h0, 3'd4, 32'd0,  8'h00, 16'hFF34, 1'b0}, // R3
    '{16'hA5C3, 4'h4, 4'h2, 3'd4, 32'd0,  8'h00, 16'hA5C3, 1'b0}, // R3
    '{16'h0000, 4'h0, 4'h0, 3'd0, 32'd5,  8'h00, 16'h001F, 1'b0}, // R4
    '{16'h0000, 4'h0, 4'h0, 3'd1, 32'd3,  8'h00, 16'h003F, 1'b0}, // R4
    '{16'h0000, 4'h0, 4'h0, 3'd2, 32'd4,  8'h00, 16'hFFFF, 1'b0}, // R4
    '{16'h0000, 4'h0, 4'h0, 3'd3, 32'd1,  8'h00, 16'h00FF, 1'b0}, // R4
    '{16'h0000, 4'h0, 4'h0, 3'd0, 32'd0,  8'h00, 16'h0000, 1'b0}, // R4
    '{16'h0000, 4'h0, 4'h0, 3'd2, 32'd5,  8'h00, 16'hFFFF, 1'b0}, // R5
    '{16'h0000, 4'h0, 4'h0, 3'd7, 32'd1,  8'h00, 16'hFFFF, 1'b0}, // R5
    '{16'h0000, 4'h0, 4'h0, 3'd0, 32'hFFFFFFFF, 8'h00, 16'hFFFF, 1'b0}, // R5
    '{16'h0000, 4'h0, 4'h0, 3'd4, 32'd0,  8'h10, 16'hFFF0, 1'b0}, // R7
    '{16'h0000, 4'h0, 4'h0, 3'd4, 32'd0,  8'h20, 16'hFF00, 1'b0}, // R7
    '{16'h0000, 4'h0, 4'h0, 3'd4, 32'd0,  8'h40, 16'hF000, 1'b0}, // R8
    '{16'h0000, 4'h0, 4'h0, 3'd4, 32'd0,  8'h21, 16'hFFFF, 1'b0}, // R6
    '{16'h0000, 4'h0, 4'h0, 3'd4, 32'd0,  8'h70, 16'hFFFF, 1'b1}, // R9
    '{16'h0F0F, 4'h1, 4'h1, 3'd0, 32'd12, 8'h10, 16'h0F00, 1'b0}  // R10
  };

  // Independent lane-by-lane model of the requirements.
  function automatic logic [16:0] refModel(logic [15:0] p, logic [3:0] lo, logic [3:0] hi,
                                           logic [2:0] sz, logic [31:0] cnt, logic [7:0] bs);
    logic [15:0] m;
    logic err = 1'b0;
    int skipLanes = 0;
    bit tail;
    longint keep;
    tail = (sz < 3'd4) && (cnt <= (32'd16 >> sz));
    keep = longint'(cnt) * (longint'(1) << sz);
    if (bs[3:0] == 4'd0) begin
      case (bs[7:4])
        4'd0: skipLanes = 0;
        4'd1: skipLanes = 4;
        4'd2: skipLanes = 8;
        4'd3, 4'd4: skipLanes = 12;
        default: err = 1'b1;
      endcase
    end
    for (int i = 0; i < 16; i++) begin
      bit on;
      on = p[i] || (i < 8 ? (lo == 4'd0) : (hi == 4'd0));
      if (tail && longint'(i) >= keep) on = 1'b0;
      if (i < skipLanes) on = 1'b0;
      m[i] = on;
    end
    return {err, m};
  endfunction

  task automatic applyAndCheck(input logic [15:0] p, input logic [3:0] lo, input logic [3:0] hi,
                               input logic [2:0] sz, input logic [31:0] cnt, input logic [7:0] bs,
                               input logic [15:0] expMask, input logic expErr, input string req);
    predBits = p; blockMaskLo = lo; blockMaskHi = hi;
    sizeCode = sz; loopCount = cnt; beatState = bs;
    #1;
    checks++;
    if (laneMask !== expMask || beatIllegal !== expErr) begin
      errors++;
      $display("FAIL %s: mask=%h err=%b expected mask=%h err=%b (p=%h lo=%h hi=%h sz=%0d cnt=%0d bs=%h)",
               req, laneMask, beatIllegal, expMask, expErr, p, lo, hi, sz, cnt, bs);
    end
  endtask

  localparam logic [15:0] PATS [4] = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h3C96};
  localparam logic [3:0]  LOS  [3] = '{4'h0, 4'h1, 4'h8};
  localparam logic [3:0]  HIS  [2] = '{4'h0, 4'hF};
  localparam logic [3:0]  LOWN [2] = '{4'h0, 4'h5};

  initial begin
    predBits = '0; blockMaskLo = '0; blockMaskHi = '0;
    sizeCode = 3'd4; loopCount = '0; beatState = '0;
    @(negedge clk);
    // R1: idle inputs give the all-lanes mask
    applyAndCheck(16'h0, 4'h0, 4'h0, 3'd4, 32'd0, 8'h00, 16'hFFFF, 1'b0, "R1");

    for (int v = 0; v < NV; v++) begin
      applyAndCheck(VECS[v].pred, VECS[v].lo, VECS[v].hi, VECS[v].size, VECS[v].cnt,
                    VECS[v].beat, VECS[v].expMask, VECS[v].expErr, "R1-table");
    end

    // R10 combined sweep also covering R2 R3 R4 R5 R6 R7 R8 R9
    for (int pi = 0; pi < 4; pi++)
      for (int li = 0; li < 3; li++)
        for (int hi = 0; hi < 2; hi++)
          for (int sz = 0; sz < 8; sz++)
            for (int c = 0; c < 19; c++)
              for (int bh = 0; bh < 16; bh++)
                for (int bl = 0; bl < 2; bl++) begin
                  logic [31:0] cnt;
                  logic [7:0] bs;
                  logic [16:0] r;
                  cnt = (c == 18) ? 32'h8000_0000 : 32'(c);
                  bs = {4'(bh), LOWN[bl]};
                  r = refModel(PATS[pi], LOS[li], HIS[hi], 3'(sz), cnt, bs);
                  applyAndCheck(PATS[pi], LOS[li], HIS[hi], 3'(sz), cnt, bs, r[15:0], r[16], "R10-sweep");
                end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < 190000; cyc++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule